// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block runs single accesses to an external asynchronous memory or peripheral. A host raises a one-cycle request that carries an address, write data and a direction flag. The controller then drives the device side through three timed phases: address setup, strobe and hold. The read and write directions each have their own programmable cycle count for every phase, so slow and fast devices can share the same controller logic. When the hold phase ends, the host sees a one-cycle acknowledge, and for a read the captured data is presented at the same time.

In extended-wait mode, a device can slow an access down by raising a wait input. That input arrives asynchronously. It passes through a two-stage synchronizer and a pulse filter, so a level counts only when it is seen high at two consecutive clock edges. The filtered level is examined once per access, at the cycle where exactly four cycles of setup plus strobe remain. If it is high then, the strobe phase stops counting until the filtered wait falls. At every other time the wait line is ignored. Wait is also ignored completely when the effective setup count plus strobe count is four or less.

Top module: `amem_strobe_ctrl`

## Requirements
- R1: Every access takes its setup count S, strobe count T and hold count H one after another. Chip select (`mem_cs_n`, active low) is low for exactly the S+T+H cycles that follow the accepting clock edge. `host_ack` is high for exactly one cycle, the cycle right after the last hold cycle, and chip select is already high in that cycle.
- R2: A read uses only the three read count fields. A write uses only the three write count fields.
- R3: A programmed count of 0 in any phase field gives a phase of 1 cycle.
- R4: `mem_oe_n` is low during exactly the strobe cycles of a read. `mem_we_n` is low during exactly the strobe cycles of a write. `mem_dout_en` is high for every cycle of a write access and low at all other times. Throughout a write access, `mem_dout` carries the write data.
- R5: For a read, `host_rdata` takes the value of `mem_din` sampled at the clock edge that closes the last strobe cycle. A write leaves `host_rdata` unchanged.
- R6: Raw `mem_wait` counts only after it has been sampled high at two consecutive clock edges. A single-cycle high pulse has no effect on the access.
- R7: Number the first setup cycle as cycle 0. In cycle S+T-4, the filtered wait is examined. If it is high, the strobe phase stops counting from the next cycle on, for as long as the filtered wait stays high. After that, the remaining strobe cycles and the hold phase run. Assume raw wait is held high from before the access and is first sampled low at the edge that ends cycle r, with T of 3 or more. The strobe then lasts T + r + 2 - (S+T-4) cycles.
- R8: The level of `mem_wait` in any cycle other than the examination point does not change the access timing. This covers toggling before the window and a rise after it.
- R9: Wait extension happens only when `cfg_wait_en` is 1 and the effective S+T is greater than 4. The rule applies to reads and to writes.
- R10: A request is accepted only while the controller is idle, and the acknowledge cycle counts as idle. A request raised during an access is dropped. Address and write data are registered at acceptance, so later changes on the host inputs do not reach the device pins.
- R11: During reset, chip select, output enable and write enable are high, `host_ack` and `mem_dout_en` are low, and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rd_setup | input | CW | Read setup count |
| cfg_rd_strobe | input | CW | Read strobe count |
| cfg_rd_hold | input | CW | Read hold count |
| cfg_wr_setup | input | CW | Write setup count |
| cfg_wr_strobe | input | CW | Write strobe count |
| cfg_wr_hold | input | CW | Write hold count |
| cfg_wait_en | input | 1 | Extended-wait mode enable |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 selects a write, 0 selects a read |
| host_addr | input | AW | Access address |
| host_wdata | input | DW | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Device address |
| mem_dout | output | DW | Device write data |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DW | Device read data |
| mem_wait | input | 1 | Asynchronous wait request from the device |

## Verification
The bench counts cycles from the first setup cycle, which is the cycle after the accepting edge. All outputs are sampled at the falling edge. Chip select, the strobes and the drive enable change at the first edge of each phase, with no further latency. The acknowledge appears in cycle S+T+H of this count, and read data is valid in that same cycle. Changes on the wait line act with a delay: a rise reaches the filtered level three edges after it is first sampled, and a fall reaches it two edges after. Every expected strobe length for wait is worked out from the fall formula in R7. Each wait pattern is driven per cycle index, so the examination point lands on a known cycle.

// File: rtl/amem_pkg.sv
`timescale 1ns/1ps
package amem_pkg;
    // Cycles of setup+strobe still ahead when the wait level is examined
    parameter int WAIT_LEAD = 4;
    // Synchronizer depth and minimum accepted pulse length, in clocks
    parameter int SYNC_STAGES = 2;
    parameter int MIN_PULSE = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;
endpackage

// File: rtl/amem_wait_filter.sv
`timescale 1ns/1ps
module amem_wait_filter #(
    parameter int STAGES = amem_pkg::SYNC_STAGES,
    parameter int PULSE  = amem_pkg::MIN_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_raw,
    output logic wait_ok
);
    localparam int LEN = STAGES + PULSE - 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], wait_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // Synchronized level must be high in PULSE consecutive samples
    assign wait_ok = &sh_q[LEN-1 -: PULSE];
endmodule

// File: rtl/amem_timing_sel.sv
`timescale 1ns/1ps
module amem_timing_sel #(
    parameter int CW = 4
) (
    input  logic          sel_we,
    input  logic          wait_en,
    input  logic [CW-1:0] rd_setup,
    input  logic [CW-1:0] rd_strobe,
    input  logic [CW-1:0] rd_hold,
    input  logic [CW-1:0] wr_setup,
    input  logic [CW-1:0] wr_strobe,
    input  logic [CW-1:0] wr_hold,
    output logic [CW-1:0] t_setup,
    output logic [CW-1:0] t_strobe,
    output logic [CW-1:0] t_hold,
    output logic          wait_elig
);
    localparam int NPH = 3;
    localparam logic [CW:0] LEAD = (CW+1)'(amem_pkg::WAIT_LEAD);

    logic [NPH-1:0][CW-1:0] pick_c;
    logic [NPH-1:0][CW-1:0] eff_c;

    always_comb begin
        if (sel_we) pick_c = {wr_hold, wr_strobe, wr_setup};
        else        pick_c = {rd_hold, rd_strobe, rd_setup};
    end

    // Zero in any phase field is raised to one cycle
    for (genvar g = 0; g < NPH; g++) begin : g_clamp
        assign eff_c[g] = (pick_c[g] == '0) ? CW'(1) : pick_c[g];
    end

    assign t_setup  = eff_c[0];
    assign t_strobe = eff_c[1];
    assign t_hold   = eff_c[2];
    assign wait_elig = wait_en && (({1'b0, eff_c[0]} + {1'b0, eff_c[1]}) > LEAD);
endmodule

// File: rtl/amem_strobe_ctrl.sv
`timescale 1ns/1ps
module amem_strobe_ctrl #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_rd_setup,
    input  logic [CW-1:0] cfg_rd_strobe,
    input  logic [CW-1:0] cfg_rd_hold,
    input  logic [CW-1:0] cfg_wr_setup,
    input  logic [CW-1:0] cfg_wr_strobe,
    input  logic [CW-1:0] cfg_wr_hold,
    input  logic          cfg_wait_en,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ack,
    output logic [DW-1:0] host_rdata,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en,
    input  logic [DW-1:0] mem_din,
    input  logic          mem_wait
);
    import amem_pkg::*;

    localparam logic [CW:0]   LEAD = (CW+1)'(WAIT_LEAD);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [CW-1:0] stb_len;
        logic [CW-1:0] hold_len;
        logic          elig;
        logic          stall;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          ack;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          wait_ok;
    logic [CW-1:0] sel_setup, sel_strobe, sel_hold;
    logic          sel_elig;
    logic [CW:0]   left_c;
    logic          probe_c;

    amem_wait_filter #(
        .STAGES(SYNC_STAGES),
        .PULSE (MIN_PULSE)
    ) wait_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_raw(mem_wait),
        .wait_ok (wait_ok)
    );

    amem_timing_sel #(.CW(CW)) tsel_i (
        .sel_we   (host_we),
        .wait_en  (cfg_wait_en),
        .rd_setup (cfg_rd_setup),
        .rd_strobe(cfg_rd_strobe),
        .rd_hold  (cfg_rd_hold),
        .wr_setup (cfg_wr_setup),
        .wr_strobe(cfg_wr_strobe),
        .wr_hold  (cfg_wr_hold),
        .t_setup  (sel_setup),
        .t_strobe (sel_strobe),
        .t_hold   (sel_hold),
        .wait_elig(sel_elig)
    );

    // Cycles of setup plus strobe still to run, this one included
    always_comb begin
        case (ctl_q.ph)
            PH_SETUP:  left_c = {1'b0, ctl_q.cnt} + {1'b0, ctl_q.stb_len};
            PH_STROBE: left_c = {1'b0, ctl_q.cnt};
            default:   left_c = '0;
        endcase
        probe_c = ctl_q.elig && (left_c == LEAD);
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;

        // Stall is armed only at the probe cycle, then follows the filtered level down
        if (probe_c) ctl_d.stall = wait_ok;
        else         ctl_d.stall = ctl_q.stall & wait_ok;

        case (ctl_q.ph)
            PH_IDLE: begin
                if (host_req) begin
                    ctl_d.ph       = PH_SETUP;
                    ctl_d.cnt      = sel_setup;
                    ctl_d.stb_len  = sel_strobe;
                    ctl_d.hold_len = sel_hold;
                    ctl_d.elig     = sel_elig;
                    ctl_d.stall    = 1'b0;
                    ctl_d.we       = host_we;
                    ctl_d.addr     = host_addr;
                    ctl_d.wdata    = host_wdata;
                end
            end
            PH_SETUP: begin
                if (ctl_q.cnt == ONE) begin
                    ctl_d.ph  = PH_STROBE;
                    ctl_d.cnt = ctl_q.stb_len;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - ONE;
                end
            end
            PH_STROBE: begin
                if (!ctl_q.stall) begin
                    if (ctl_q.cnt == ONE) begin
                        ctl_d.ph  = PH_HOLD;
                        ctl_d.cnt = ctl_q.hold_len;
                        if (!ctl_q.we) ctl_d.rdata = mem_din;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - ONE;
                    end
                end
            end
            PH_HOLD: begin
                if (ctl_q.cnt == ONE) begin
                    ctl_d.ph    = PH_IDLE;
                    ctl_d.ack   = 1'b1;
                    ctl_d.stall = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - ONE;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mem_cs_n    = (ctl_q.ph == PH_IDLE);
    assign mem_oe_n    = !((ctl_q.ph == PH_STROBE) && !ctl_q.we);
    assign mem_we_n    = !((ctl_q.ph == PH_STROBE) && ctl_q.we);
    assign mem_dout_en = (ctl_q.ph != PH_IDLE) && ctl_q.we;
    assign mem_addr    = ctl_q.addr;
    assign mem_dout    = ctl_q.wdata;
    assign host_ack    = ctl_q.ack;
    assign host_rdata  = ctl_q.rdata;
endmodule

// File: rtl/amem_strobe_chk.sv
`timescale 1ns/1ps
module amem_strobe_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_ack,
    input logic [DW-1:0] host_rdata,
    input logic          mem_cs_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dout_en,
    input logic [AW-1:0] mem_addr
);
    // R4: a strobe only ever appears inside an active chip select
    a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    // R4: reads never drive the data bus
    a_r4_oe_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dout_en);

    // R1: acknowledge is a single-cycle pulse
    a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R1: acknowledge follows the end of an access
    a_r1_ack_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> (mem_cs_n && $past(!mem_cs_n)));

    // R10: address held steady for the whole access
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R5: read data only moves at the end of a read strobe
    a_r5_rdata_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_rdata) |-> $past(!mem_oe_n));
endmodule

bind amem_strobe_ctrl amem_strobe_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ack   (host_ack),
    .host_rdata (host_rdata),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dout_en(mem_dout_en),
    .mem_addr   (mem_addr)
);

// File: tb/amem_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module amem_strobe_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_rd_setup = '0, cfg_rd_strobe = '0, cfg_rd_hold = '0;
    logic [CW-1:0] cfg_wr_setup = '0, cfg_wr_strobe = '0, cfg_wr_hold = '0;
    logic          cfg_wait_en = 1'b0;
    logic          host_req = 1'b0, host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ack;
    logic [DW-1:0] host_rdata;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout;
    logic [DW-1:0] mem_din = '0;
    logic          mem_wait = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    amem_strobe_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
        .cfg_wait_en(cfg_wait_en),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_wait(mem_wait)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // One access; wpat[c] is the raw wait level driven during cycle c (cycle 0 = first setup cycle)
    task automatic run_access(input string tag, input logic we,
                              input logic [CW-1:0] s, input logic [CW-1:0] t, input logic [CW-1:0] h,
                              input logic ext, input logic pre, input logic [63:0] wpat,
                              input int es, input int et, input int eh, input logic busy);
        int a_idx, first_stb, stb_cnt, last_stb, cs_gap, bad_stb, addr_bad, dout_bad;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd, rd_before;
        addr = 16'h1000 + 16'(n_chk);
        wd   = 16'h5A00 ^ 16'(n_chk);
        if (we) begin
            cfg_wr_setup = s; cfg_wr_strobe = t; cfg_wr_hold = h;
            cfg_rd_setup = 4'd7; cfg_rd_strobe = 4'd7; cfg_rd_hold = 4'd7;
        end else begin
            cfg_rd_setup = s; cfg_rd_strobe = t; cfg_rd_hold = h;
            cfg_wr_setup = 4'd7; cfg_wr_strobe = 4'd7; cfg_wr_hold = 4'd7;
        end
        cfg_wait_en = ext;
        mem_wait = pre;
        repeat (4) @(negedge clk);
        rd_before = host_rdata;
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0; host_addr = ~addr; host_wdata = ~wd;
        a_idx = -1; first_stb = -1; stb_cnt = 0; last_stb = 0;
        cs_gap = 0; bad_stb = 0; addr_bad = 0; dout_bad = 0;
        for (int c = 0; c < 60; c++) begin
            if (host_ack) begin
                a_idx = c;
                break;
            end
            if (mem_cs_n) cs_gap++;
            if (mem_addr != addr) addr_bad++;
            if (we && (!mem_dout_en || mem_dout != wd)) dout_bad++;
            if (!we && mem_dout_en) dout_bad++;
            if ((we && !mem_oe_n) || (!we && !mem_we_n)) bad_stb++;
            if (!mem_oe_n || !mem_we_n) begin
                if (first_stb < 0) first_stb = c;
                stb_cnt++;
                last_stb = c;
            end
            mem_wait = wpat[c];
            mem_din  = 16'hA000 + 16'(c);
            host_req = busy && (c == 1 || c == 2);
            @(negedge clk);
        end
        host_req = 1'b0;
        chk("R1", {tag, " ack seen"}, (a_idx >= 0) ? 1 : 0, 1);
        chk(tag, "setup cycles", first_stb, es);
        chk(tag, "strobe cycles", stb_cnt, et);
        chk(tag, "hold cycles", a_idx - first_stb - stb_cnt, eh);
        chk("R1", {tag, " cs gaps"}, cs_gap, 0);
        chk("R1", {tag, " cs_n at ack"}, int'(mem_cs_n), 1);
        chk("R4", {tag, " wrong strobe"}, bad_stb, 0);
        chk("R4", {tag, " data drive"}, dout_bad, 0);
        chk("R10", {tag, " addr latched"}, addr_bad, 0);
        if (we) chk("R5", {tag, " rdata kept on write"}, int'(host_rdata), int'(rd_before));
        else    chk("R5", {tag, " rdata last strobe"}, int'(host_rdata), int'(16'hA000 + 16'(last_stb)));
        @(negedge clk);
        chk("R1", {tag, " ack one cycle"}, int'(host_ack), 0);
        if (busy) begin
            for (int k = 0; k < 3; k++) begin
                chk("R10", {tag, " busy req dropped"}, int'(mem_cs_n), 1);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset;
        chk("R11", "cs_n", int'(mem_cs_n), 1);
        chk("R11", "oe_n", int'(mem_oe_n), 1);
        chk("R11", "we_n", int'(mem_we_n), 1);
        chk("R11", "ack", int'(host_ack), 0);
        chk("R11", "dout_en", int'(mem_dout_en), 0);
        chk("R11", "rdata", int'(host_rdata), 0);
    endtask

    task automatic t_basic;
        run_access("R1 read", 1'b0, 4'd1, 4'd2, 4'd1, 1'b0, 1'b0, 64'h0, 1, 2, 1, 1'b0);
        run_access("R2 write", 1'b1, 4'd3, 4'd4, 4'd2, 1'b0, 1'b0, 64'h0, 3, 4, 2, 1'b1);
        run_access("R2 read", 1'b0, 4'd2, 4'd5, 4'd3, 1'b0, 1'b0, 64'h0, 2, 5, 3, 1'b0);
    endtask

    task automatic t_zero_counts;
        run_access("R3 read zeros", 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 64'h0, 1, 1, 1, 1'b0);
        run_access("R3 write zeros", 1'b1, 4'd0, 4'd5, 4'd0, 1'b0, 1'b0, 64'h0, 1, 5, 1, 1'b0);
    endtask

    task automatic t_wait_extend;
        // S=2 T=6: probe cycle 4, release r=10 -> 6+10+2-4 = 14
        run_access("R7 read stall", 1'b0, 4'd2, 4'd6, 4'd2, 1'b1, 1'b1, 64'h3FF, 2, 14, 2, 1'b0);
        // S=4 T=3: probe in last setup cycle 3, r=6 -> 3+6+2-3 = 8
        run_access("R7 probe in setup", 1'b0, 4'd4, 4'd3, 4'd1, 1'b1, 1'b1, 64'h3F, 4, 8, 1, 1'b0);
        // S=1 T=4 (sum 5, eligible) write: probe 1, r=5 -> 4+5+2-1 = 10
        run_access("R9 write boundary", 1'b1, 4'd1, 4'd4, 4'd1, 1'b1, 1'b1, 64'h1F, 1, 10, 1, 1'b0);
    endtask

    task automatic t_pulse_filter;
        run_access("R6 single pulse", 1'b0, 4'd2, 4'd6, 4'd1, 1'b1, 1'b0, 64'h4, 2, 6, 1, 1'b0);
        // two samples high -> filtered high only in probe cycle -> one frozen cycle
        run_access("R6 double pulse", 1'b0, 4'd2, 4'd6, 4'd1, 1'b1, 1'b0, 64'h6, 2, 7, 1, 1'b0);
    endtask

    task automatic t_outside_window;
        run_access("R8 glitch before", 1'b0, 4'd2, 4'd6, 4'd1, 1'b1, 1'b1, 64'h2, 2, 6, 1, 1'b0);
        run_access("R8 late rise", 1'b1, 4'd2, 4'd6, 4'd1, 1'b1, 1'b0, 64'h1FF8, 2, 6, 1, 1'b0);
    endtask

    task automatic t_ineligible;
        run_access("R9 read sum4", 1'b0, 4'd1, 4'd3, 4'd1, 1'b1, 1'b1, '1, 1, 3, 1, 1'b0);
        run_access("R9 write sum4", 1'b1, 4'd2, 4'd2, 4'd2, 1'b1, 1'b1, '1, 2, 2, 2, 1'b0);
        run_access("R9 mode off", 1'b0, 4'd2, 4'd6, 4'd1, 1'b0, 1'b1, '1, 2, 6, 1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected<%0d", 200000, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_zero_counts();
        t_wait_extend();
        t_pulse_filter();
        t_outside_window();
        t_ineligible();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule